// File: doc/BRIEF.md
# Bit Field Extract Unit

This block takes a source word and a control word and returns one contiguous run of source bits. The run is shifted down so that its lowest bit lands at result bit 0, and every result bit above it is zero. The control word carries two 8-bit numbers: the index of the lowest source bit to take, and how many bits to take. Start and length values that run past the operand width are not errors. The unit clips them, so the result only ever holds real source bits or zeros.

The operand width is a parameter and may be 32 or 64 bits. The control port has the same width as the operand, but only its low 16 bits have any meaning. A second parameter selects the output stage. In registered mode the result, a zero flag and a valid strobe come out one clock after the input strobe. In combinational mode they follow the inputs in the same cycle. The unit is meant as one lane of an integer execute stage.

Top module: `bfx_unit`

## Requirements
- R1: Control bits [7:0] give the start index S and bits [15:8] give the length L. The result holds source bits S up to S+L-1 at result bits 0 up to L-1, and every result bit from L upward is zero. For example, source 0x50 with S=4 and L=4 gives 0x5.
- R2: Control bits 16 and above have no effect on the result.
- R3: When S is greater than or equal to the operand width, the result is zero. This includes S=255.
- R4: When S+L exceeds the operand width, the field stops at the top source bit, so the result equals the source shifted right by S.
- R5: L=0 gives a zero result. An L of at least the operand width, with S=0, returns the whole source.
- R6: The zero flag is 1 exactly when the result is all zeros.
- R7: In registered mode, an accepted input appears on the result together with out_valid=1 one clock after in_valid was high. A cycle with in_valid low produces out_valid=0 one clock later.
- R8: In registered mode, the result and the zero flag keep their values while in_valid is low, whatever the source and control inputs do.
- R9: In registered mode, reset drives out_valid to 0, the result to 0 and the zero flag to 1.
- R10: In combinational mode, out_valid equals in_valid and the result follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Source and control are valid this cycle |
| src_i | input | DATA_W | Source operand |
| ctrl_i | input | DATA_W | Control word: [7:0] start, [15:8] length; upper bits unused |
| out_valid_o | output | 1 | Result is valid |
| result_o | output | DATA_W | Extracted field, right-justified and zero-extended |
| zero_o | output | 1 | Result is all zeros |

## Verification
The hardest cases are the clipping corners, where S is just below the width and L is large, or S is at or above the width. These cases are easy to overlook, because an unclipped shifter would give the right answer for every short field. The stimulus table drives S=28 and S=31 against a 32-bit operand, S=32 and S=255, L=32 and L=255, and S=1 with L=32. A second, combinational 64-bit instance receives the same stimulus and is checked against a bit-by-bit model, and directed cases cover S=63 and S=64. Hold behaviour is reached by dropping in_valid while the source and control are changed to values that would give a different result.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

   // Layout of the low 16 bits of the control word; decoding depends on it.
   typedef struct packed {
      logic [7:0] len;    // bits [15:8]
      logic [7:0] start;  // bits [7:0]
   } bfx_ctl_t;

   localparam int unsigned CTL_W = $bits(bfx_ctl_t);

   function automatic bit width_ok(int unsigned w);
      return (w == 32) || (w == 64);
   endfunction

endpackage

// File: rtl/bfx_ctl_decode.sv
module bfx_ctl_decode
   import bfx_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(DATA_W),
   localparam int unsigned LEN_W = IDX_W + 1
) (
   input  bfx_ctl_t           ctl_i,
   output logic [IDX_W-1:0]   start_idx_o,
   output logic               start_oor_o,
   output logic [LEN_W-1:0]   len_sat_o
);

   localparam logic [7:0] WIDTH_8 = 8'(DATA_W);

   logic [IDX_W-1:0] unused_start_hi_dummy;

   always_comb begin
      start_oor_o = (ctl_i.start >= WIDTH_8);
      start_idx_o = ctl_i.start[IDX_W-1:0];
      if (ctl_i.len >= WIDTH_8) begin
         len_sat_o = LEN_W'(DATA_W);
      end else begin
         len_sat_o = ctl_i.len[LEN_W-1:0];
      end
   end

   assign unused_start_hi_dummy = '0;

endmodule

// File: rtl/bfx_shift.sv
module bfx_shift #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [IDX_W-1:0]  start_idx_i,
   input  logic              start_oor_i,
   output logic [DATA_W-1:0] shifted_o
);

   // Logarithmic barrel shifter: one mux stage per index bit.
   logic [DATA_W-1:0] stage [IDX_W+1];

   assign stage[0] = start_oor_i ? '0 : src_i;

   for (genvar s = 0; s < IDX_W; s++) begin : g_stage
      assign stage[s+1] = start_idx_i[s] ? (stage[s] >> (1 << s)) : stage[s];
   end

   assign shifted_o = stage[IDX_W];

endmodule

// File: rtl/bfx_mask.sv
module bfx_mask #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(DATA_W),
   localparam int unsigned LEN_W = IDX_W + 1
) (
   input  logic [DATA_W-1:0] shifted_i,
   input  logic [LEN_W-1:0]  len_sat_i,
   output logic [DATA_W-1:0] field_o,
   output logic              zero_o
);

   logic [DATA_W-1:0] keep;

   // Thermometer mask: bit i is kept when i lies below the saturated length.
   for (genvar i = 0; i < DATA_W; i++) begin : g_keep
      assign keep[i] = (LEN_W'(i) < len_sat_i);
   end

   assign field_o = shifted_i & keep;
   assign zero_o  = ~|(shifted_i & keep);

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
   import bfx_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned IDX_W  = $clog2(DATA_W),
   localparam int unsigned LEN_W  = IDX_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] ctrl_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] result_o,
   output logic              zero_o
);

   if (!width_ok(DATA_W)) begin : g_bad_width
      $error("bfx_unit: DATA_W must be 32 or 64");
   end

   bfx_ctl_t          ctl;
   logic [IDX_W-1:0]  start_idx;
   logic              start_oor;
   logic [LEN_W-1:0]  len_sat;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] field;
   logic              field_zero;
   logic              unused_ctl_hi;

   assign ctl           = bfx_ctl_t'(ctrl_i[CTL_W-1:0]);
   assign unused_ctl_hi = ^ctrl_i[DATA_W-1:CTL_W];

   bfx_ctl_decode #(.DATA_W(DATA_W)) i_decode (
      .ctl_i       (ctl),
      .start_idx_o (start_idx),
      .start_oor_o (start_oor),
      .len_sat_o   (len_sat)
   );

   bfx_shift #(.DATA_W(DATA_W)) i_shift (
      .src_i       (src_i),
      .start_idx_i (start_idx),
      .start_oor_i (start_oor),
      .shifted_o   (shifted)
   );

   bfx_mask #(.DATA_W(DATA_W)) i_mask (
      .shifted_i (shifted),
      .len_sat_i (len_sat),
      .field_o   (field),
      .zero_o    (field_zero)
   );

   if (REG_OUT) begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] res_q;
      logic              zero_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vld_q  <= 1'b0;
            res_q  <= '0;
            zero_q <= 1'b1;
         end else begin
            vld_q <= in_valid_i;
            if (in_valid_i) begin
               res_q  <= field;
               zero_q <= field_zero;
            end
         end
      end

      assign out_valid_o = vld_q;
      assign result_o    = res_q;
      assign zero_o      = zero_q;

      p_lat_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_valid_i |=> out_valid_o);
      p_lat_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !in_valid_i |=> !out_valid_o);
      p_lat_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_valid_i |=> (result_o == $past(field)));
      p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !in_valid_i |=> ($stable(result_o) && $stable(zero_o)));
   end else begin : g_comb
      assign out_valid_o = in_valid_i;
      assign result_o    = field;
      assign zero_o      = field_zero;
   end

   p_zero_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_o == (result_o == '0));
   p_oor_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_oor |-> (field == '0));
   p_len_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (len_sat == '0) |-> (field == '0));
   p_upper_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (field >> len_sat) == '0);

endmodule

// File: tb/test_bfx_unit.sv
module test_bfx_unit;

   localparam int NV = 13;

   // Stimulus table for the 32-bit registered instance.
   // ctrl[7:0] = start, ctrl[15:8] = length.
   localparam logic [31:0] V_SRC [NV] = '{
      32'h0000_0050,  // R1 example
      32'hDEAD_BEEF,  // R1 start 8 len 8
      32'hDEAD_BEEF,  // R1 start 0 len 16
      32'hDEAD_BEEF,  // R4 start 28 len 16 clipped
      32'hDEAD_BEEF,  // R3 start 32
      32'hFFFF_FFFF,  // R3 start 255
      32'hDEAD_BEEF,  // R5 len 0
      32'hDEAD_BEEF,  // R5 len 255 start 0
      32'hDEAD_BEEF,  // R2 upper control bits set
      32'h8000_0000,  // R1 top bit alone
      32'hDEAD_BEEF,  // R4 start 1 len 32
      32'h0000_0F00,  // R6 zero field from nonzero source
      32'hDEAD_BEEF   // R5 len equals width
   };
   localparam logic [31:0] V_CTL [NV] = '{
      32'h0000_0404, 32'h0000_0808, 32'h0000_1000, 32'h0000_101C,
      32'h0000_0020, 32'h0000_08FF, 32'h0000_0005, 32'h0000_FF00,
      32'hABCD_0404, 32'h0000_011F, 32'h0000_2001, 32'h0000_0400,
      32'h0000_2000
   };
   localparam logic [31:0] V_EXP [NV] = '{
      32'h0000_0005, 32'h0000_00BE, 32'h0000_BEEF, 32'h0000_000D,
      32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hDEAD_BEEF,
      32'h0000_000E, 32'h0000_0001, 32'h6F56_DF77, 32'h0000_0000,
      32'hDEAD_BEEF
   };
   localparam int V_REQ [NV] = '{1, 1, 1, 4, 3, 3, 5, 5, 2, 1, 4, 6, 5};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld = 1'b0;
   logic [31:0] src32 = '0;
   logic [31:0] ctl32 = '0;
   logic [63:0] src64 = '0;
   logic [63:0] ctl64 = '0;

   logic        r_vld, r_zero;
   logic [31:0] r_res;
   logic        c_vld, c_zero;
   logic [63:0] c_res;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bfx_unit #(.DATA_W(32), .REG_OUT(1'b1)) i_bfx_unit (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld), .src_i(src32),
      .ctrl_i(ctl32), .out_valid_o(r_vld), .result_o(r_res), .zero_o(r_zero)
   );

   bfx_unit #(.DATA_W(64), .REG_OUT(1'b0)) i_bfx_unit_comb (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld), .src_i(src64),
      .ctrl_i(ctl64), .out_valid_o(c_vld), .result_o(c_res), .zero_o(c_zero)
   );

   // Bit-by-bit model of the requirements for a 64-bit operand.
   function automatic logic [63:0] ref64(logic [63:0] s, logic [63:0] c);
      int st = int'(c[7:0]);
      int ln = int'(c[15:8]);
      logic [63:0] r = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < ln && st + i < 64) r[i] = s[st+i];
      end
      return r;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one operation; check the combinational instance in-cycle and
   // the registered one after the capturing edge.
   task automatic run_op(int req, logic [31:0] s, logic [31:0] c, logic [31:0] e);
      logic [63:0] e64;
      @(negedge clk);
      src32 = s;
      ctl32 = c;
      src64 = {~s, s};
      ctl64 = {32'h0, c};
      vld   = 1'b1;
      #1;
      e64 = ref64({~s, s}, {32'h0, c});
      check($sformatf("R10/R%0d comb result", req), c_res, e64);
      check("R10 comb valid", {63'h0, c_vld}, 64'h1);
      check("R6 comb zero", {63'h0, c_zero}, {63'h0, e64 == 64'h0});
      @(negedge clk);
      check($sformatf("R7/R%0d reg result", req), {32'h0, r_res}, {32'h0, e});
      check("R7 reg valid", {63'h0, r_vld}, 64'h1);
      check("R6 reg zero", {63'h0, r_zero}, {63'h0, e == 32'h0});
      vld = 1'b0;
   endtask

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9 reset valid", {63'h0, r_vld}, 64'h0);
      check("R9 reset result", {32'h0, r_res}, 64'h0);
      check("R9 reset zero", {63'h0, r_zero}, 64'h1);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         run_op(V_REQ[k], V_SRC[k], V_CTL[k], V_EXP[k]);
      end

      // R8 and R7: drop valid and change the inputs; output must hold.
      run_op(1, 32'hDEAD_BEEF, 32'h0000_0808, 32'h0000_00BE);
      src32 = 32'hFFFF_FFFF;
      ctl32 = 32'h0000_2000;
      src64 = '1;
      ctl64 = 64'h2000;
      #1;
      check("R10 comb valid low", {63'h0, c_vld}, 64'h0);
      @(negedge clk);
      check("R7 valid low", {63'h0, r_vld}, 64'h0);
      check("R8 result held", {32'h0, r_res}, 64'hBE);
      check("R8 zero held", {63'h0, r_zero}, 64'h0);
      @(negedge clk);
      check("R8 result still held", {32'h0, r_res}, 64'hBE);

      // R7: back-to-back operations
      src32 = 32'h1234_5678;
      ctl32 = 32'h0000_0C04;
      vld = 1'b1;
      @(negedge clk);
      check("R7 back-to-back first", {32'h0, r_res}, 64'h567);
      ctl32 = 32'h0000_0818;
      @(negedge clk);
      check("R7 back-to-back second", {32'h0, r_res}, 64'h12);
      check("R7 back-to-back valid", {63'h0, r_vld}, 64'h1);
      vld = 1'b0;

      // 64-bit boundaries on the combinational instance
      @(negedge clk);
      vld = 1'b1;
      src64 = 64'h8000_0000_0000_0000;
      ctl64 = 64'hFF3F;
      #1;
      check("R4 64-bit start 63", c_res, 64'h1);
      ctl64 = 64'h0840;
      src64 = '1;
      #1;
      check("R3 64-bit start 64", c_res, 64'h0);
      check("R6 64-bit zero flag", {63'h0, c_zero}, 64'h1);
      src64 = 64'h50;
      ctl64 = 64'hFFFF_FFFF_FFFF_0404;
      #1;
      check("R2 64-bit upper control", c_res, 64'h5);
      ctl64 = 64'hFF00;
      src64 = 64'hF00D_CAFE_1234_8765;
      #1;
      check("R5 64-bit full length", c_res, 64'hF00D_CAFE_1234_8765);
      vld = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule